// File: doc/BRIEF.md
# Accelerator Start/Done Control Register Block

This block is the host-facing control point of a frame-processing engine. A host reads and writes a small word-addressed register space over a simple single-cycle register bus. One control word launches the engine, reports its completion and its live status, and can arm the engine to relaunch itself after every completion. A bank of parameter registers, all reset to zero, drives configuration values straight to the engine. Storage-only interrupt-enable words sit beside the control word and influence nothing.

The launch request to the engine is a level that stays high until the engine accepts it. Acceptance is shown by the engine's ready indication while the request is high. Completion pulses are latched into a sticky done flag. The flag clears when the host reads the control word, but never at the cost of a completion that arrives in the same cycle as that read.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset, `eng_start_o` is 0 and every register is 0. A read of the control word (offset 0x00) returns only the live idle bit (bit 2), so it reads 0x4 while `eng_idle_i` is 1. Every parameter register and `param_o` read 0.
- R2: A host write to offset 0x00 loads the launch bit from data bit 0. Writing 1 drives `eng_start_o` high from the next cycle, and bit 0 of the control word reads back 1.
- R3: While `eng_start_o` is high, a cycle with `eng_ready_i` high clears the launch bit, so `eng_start_o` is low in the following cycle. A control write or an auto relaunch in that same cycle takes precedence.
- R4: A cycle with `eng_done_i` high sets the sticky done bit (bit 1). The bit stays set until a host read of offset 0x00. That read returns 1, and the next read returns 0.
- R5: If `eng_done_i` is high in the same cycle as a host read of offset 0x00, that read returns the done value held before the cycle, and the done bit is set afterwards.
- R6: Bits 2 (idle) and 3 (ready) of the control word return `eng_idle_i` and `eng_ready_i` as sampled in the cycle of the read request.
- R7: Bit 7 of the control word is read/write auto-restart. While it is set, a cycle with `eng_done_i` high sets the launch bit, so `eng_start_o` is high in the next cycle.
- R8: Writes to control bits 1 to 6 and 8 and above are ignored. Bits 4 to 6 and 8 and above always read 0.
- R9: Offset 0x04 stores data bit 0 and offset 0x08 stores data bits 1:0. Both read back with all other bits 0, and neither has any effect on `eng_start_o`. Offset 0x0C always reads 0.
- R10: Parameter register k sits at offset 0x10 + 8*k (k = 0 to NUM_PARAM-1). It is DATA_W bits wide, fully readable and writable, and drives `param_o[k*DATA_W +: DATA_W]`.
- R11: The read data appears on `bus_rdata_o` with `bus_rvalid_o` high exactly one cycle after a read request. `bus_rvalid_o` is low in all other cycles. Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset, word aligned |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | DATA_W | Read data |
| eng_start_o | output | 1 | Launch request to the engine |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_idle_i | input | 1 | Engine idle status |
| eng_ready_i | input | 1 | Engine accepts launch / ready for input |
| param_o | output | NUM_PARAM*DATA_W | Parameter register values |

## Verification
The sharpest case is a completion pulse that lands in the same cycle as a host read of the control word. A design that lets the clear win would lose that completion, and the next read would show done as 0. The bench also checks that the launch request stays high until the ready handshake, and that auto-restart raises it again only on a completion. A design that ignored the handshake would hold start forever, and one that relaunched on ready would start without a completion. It writes all-ones patterns to the status and reserved bits and to the interrupt-enable words. Any leak into the launch bit, done bit or read data then shows up at the ports.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_GIE = 'h04;
  localparam int unsigned OFS_IER = 'h08;
  localparam int unsigned OFS_ISR = 'h0C;
  localparam int unsigned OFS_PARAM = 'h10;
  localparam int unsigned PARAM_STRIDE = 8;

  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_DONE = 1;
  localparam int unsigned BIT_IDLE = 2;
  localparam int unsigned BIT_READY = 3;
  localparam int unsigned BIT_AUTO = 7;

  localparam int unsigned IER_W = 2;

  typedef struct packed {
    logic ctrl;
    logic gie;
    logic ier;
    logic isr;
  } fixed_sel_t;
endpackage

// File: rtl/accel_ctrl_field.sv
module accel_ctrl_field #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/accel_ctrl_decode.sv
module accel_ctrl_decode
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_PARAM = 4
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output fixed_sel_t           fsel_o,
  output logic [NUM_PARAM-1:0] psel_o
);
  always_comb begin
    fsel_o.ctrl = (addr_i == ADDR_W'(OFS_CTRL));
    fsel_o.gie  = (addr_i == ADDR_W'(OFS_GIE));
    fsel_o.ier  = (addr_i == ADDR_W'(OFS_IER));
    fsel_o.isr  = (addr_i == ADDR_W'(OFS_ISR));
  end

  for (genvar k = 0; k < NUM_PARAM; k++) begin : g_psel
    localparam int unsigned OFS = OFS_PARAM + k * PARAM_STRIDE;
    assign psel_o[k] = (addr_i == ADDR_W'(OFS));
  end
endmodule

// File: rtl/accel_ctrl_core.sv
module accel_ctrl_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_rd_i,
  input  logic start_wd_i,
  input  logic auto_wd_i,
  input  logic eng_done_i,
  input  logic eng_ready_i,
  output logic start_o,
  output logic done_o,
  output logic auto_o
);
  logic start_d, done_d, auto_d;

  // priority: host write > auto relaunch > handshake clear
  always_comb begin
    start_d = start_o;
    if (start_o && eng_ready_i) start_d = 1'b0;
    if (eng_done_i && auto_o)   start_d = 1'b1;
    if (ctrl_wr_i)              start_d = start_wd_i;
  end

  // a fresh completion beats the clear-on-read
  always_comb begin
    done_d = done_o;
    if (ctrl_rd_i)  done_d = 1'b0;
    if (eng_done_i) done_d = 1'b1;
  end

  assign auto_d = ctrl_wr_i ? auto_wd_i : auto_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      auto_o  <= 1'b0;
    end else begin
      start_o <= start_d;
      done_o  <= done_d;
      auto_o  <= auto_d;
    end
  end
endmodule

// File: rtl/accel_ctrl_rdmux.sv
module accel_ctrl_rdmux
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_PARAM = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_i,
  input  fixed_sel_t                  fsel_i,
  input  logic [NUM_PARAM-1:0]        psel_i,
  input  logic                        start_i,
  input  logic                        done_i,
  input  logic                        idle_i,
  input  logic                        ready_i,
  input  logic                        auto_i,
  input  logic                        gie_i,
  input  logic [IER_W-1:0]            ier_i,
  input  logic [NUM_PARAM*DATA_W-1:0] param_i,
  output logic                        rvalid_o,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    if (fsel_i.ctrl) begin
      word[BIT_START] = start_i;
      word[BIT_DONE]  = done_i;
      word[BIT_IDLE]  = idle_i;
      word[BIT_READY] = ready_i;
      word[BIT_AUTO]  = auto_i;
    end
    if (fsel_i.gie) word[0] = gie_i;
    if (fsel_i.ier) word[IER_W-1:0] = ier_i;
    // isr: no status logic, reads zero
    for (int k = 0; k < NUM_PARAM; k++) begin
      if (psel_i[k]) word = param_i[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? word : '0;
    end
  end
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_PARAM = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_valid_i,
  input  logic                        bus_write_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic                        bus_rvalid_o,
  output logic [DATA_W-1:0]           bus_rdata_o,
  output logic                        eng_start_o,
  input  logic                        eng_done_i,
  input  logic                        eng_idle_i,
  input  logic                        eng_ready_i,
  output logic [NUM_PARAM*DATA_W-1:0] param_o
);
  fixed_sel_t           fsel;
  logic [NUM_PARAM-1:0] psel;
  logic                 wr, rd;
  logic                 done_q, auto_q, gie_q;
  logic [IER_W-1:0]     ier_q;

  assign wr = bus_valid_i &  bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;

  accel_ctrl_decode #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM)) u_dec (
    .addr_i (bus_addr_i),
    .fsel_o (fsel),
    .psel_o (psel)
  );

  accel_ctrl_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (wr & fsel.ctrl),
    .ctrl_rd_i   (rd & fsel.ctrl),
    .start_wd_i  (bus_wdata_i[BIT_START]),
    .auto_wd_i   (bus_wdata_i[BIT_AUTO]),
    .eng_done_i  (eng_done_i),
    .eng_ready_i (eng_ready_i),
    .start_o     (eng_start_o),
    .done_o      (done_q),
    .auto_o      (auto_q)
  );

  accel_ctrl_field #(.W(1)) u_gie (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (wr & fsel.gie),
    .d_i (bus_wdata_i[0]), .q_o (gie_q)
  );

  accel_ctrl_field #(.W(IER_W)) u_ier (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (wr & fsel.ier),
    .d_i (bus_wdata_i[IER_W-1:0]), .q_o (ier_q)
  );

  for (genvar k = 0; k < NUM_PARAM; k++) begin : g_param
    accel_ctrl_field #(.W(DATA_W)) u_prm (
      .clk_i (clk_i), .rst_ni (rst_ni), .we_i (wr & psel[k]),
      .d_i (bus_wdata_i), .q_o (param_o[k*DATA_W +: DATA_W])
    );
  end

  accel_ctrl_rdmux #(.DATA_W(DATA_W), .NUM_PARAM(NUM_PARAM)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd),
    .fsel_i   (fsel),
    .psel_i   (psel),
    .start_i  (eng_start_o),
    .done_i   (done_q),
    .idle_i   (eng_idle_i),
    .ready_i  (eng_ready_i),
    .auto_i   (auto_q),
    .gie_i    (gie_q),
    .ier_i    (ier_q),
    .param_i  (param_o),
    .rvalid_o (bus_rvalid_o),
    .rdata_o  (bus_rdata_o)
  );
endmodule

// File: rtl/accel_ctrl_regs_chk.sv
module accel_ctrl_regs_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              wd0_i,
  input logic              bus_rvalid_o,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              eng_start_o,
  input logic              eng_done_i,
  input logic              eng_ready_i,
  input logic              auto_i,
  input logic              done_i
);
  logic ctrl_wr, ctrl_rd, rd;
  assign rd      = bus_valid_i && !bus_write_i;
  assign ctrl_wr = bus_valid_i && bus_write_i && (bus_addr_i == '0);
  assign ctrl_rd = rd && (bus_addr_i == '0);

  AST_START_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wd0_i) |=> eng_start_o); // R2

  AST_START_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && eng_ready_i && !ctrl_wr && !(eng_done_i && auto_i)) |=> !eng_start_o); // R3

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |=> done_i); // R5

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ctrl_rd) |=> done_i); // R4

  AST_AUTO_RELAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && auto_i && !ctrl_wr) |=> eng_start_o); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |=> (bus_rdata_o[6:4] == '0 && bus_rdata_o[DATA_W-1:8] == '0)); // R8

  AST_RVALID_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> bus_rvalid_o); // R11

  AST_RVALID_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !bus_rvalid_o); // R11
endmodule

bind accel_ctrl_regs accel_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .wd0_i        (bus_wdata_i[0]),
  .bus_rvalid_o (bus_rvalid_o),
  .bus_rdata_o  (bus_rdata_o),
  .eng_start_o  (eng_start_o),
  .eng_done_i   (eng_done_i),
  .eng_ready_i  (eng_ready_i),
  .auto_i       (auto_q),
  .done_i       (done_q)
);

// File: tb/accel_ctrl_regs_test.sv
module accel_ctrl_regs_test;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic rvalid;
  logic [DW-1:0] rdata;
  logic start;
  logic done_in = 1'b0, idle_in = 1'b1, ready_in = 1'b0;
  logic [NP*DW-1:0] params;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  accel_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW), .NUM_PARAM(NP)) uut (
    .clk_i (clk), .rst_ni (rst_n),
    .bus_valid_i (valid), .bus_write_i (write), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rvalid_o (rvalid), .bus_rdata_o (rdata),
    .eng_start_o (start), .eng_done_i (done_in), .eng_idle_i (idle_in),
    .eng_ready_i (ready_in), .param_o (params)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    check("R11 rvalid", {31'b0, rvalid}, 1);
    d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_in = 1'b1;
    @(negedge clk); done_in = 1'b0;
  endtask

  function automatic logic [DW-1:0] ctrl_exp(logic s, logic dn, logic au);
    return DW'({au, 3'b000, ready_in, idle_in, dn, s});
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 start", {31'b0, start}, 0);
    check("R1 params", params[DW-1:0] | params[NP*DW-1:DW], 0);
    bus_rd('h00, d); check("R1 ctrl", d, 32'h4);
    bus_rd('h18, d); check("R1 param1", d, 0);
    bus_rd('h04, d); check("R1 gie", d, 0);
    @(negedge clk);
    check("R11 rvalid idle", {31'b0, rvalid}, 0);
  endtask

  task automatic t_start_handshake();
    logic [DW-1:0] d;
    bus_wr('h00, 32'h1);
    check("R2 start out", {31'b0, start}, 1);
    @(negedge clk);
    check("R3 start held", {31'b0, start}, 1);
    bus_rd('h00, d); check("R2 ctrl start", d, ctrl_exp(1, 0, 0));
    @(negedge clk); ready_in = 1'b1;
    @(negedge clk); ready_in = 1'b0;
    check("R3 start cleared", {31'b0, start}, 0);
    bus_rd('h00, d); check("R3 ctrl start", d, ctrl_exp(0, 0, 0));
  endtask

  task automatic t_done();
    logic [DW-1:0] d;
    pulse_done();
    check("R4 no relaunch", {31'b0, start}, 0);
    bus_rd('h00, d); check("R4 done set", d, ctrl_exp(0, 1, 0));
    bus_rd('h00, d); check("R4 done cleared", d, ctrl_exp(0, 0, 0));
  endtask

  task automatic t_done_collide();
    logic [DW-1:0] d;
    @(negedge clk);
    done_in = 1'b1; valid = 1'b1; write = 1'b0; addr = 'h00;
    @(negedge clk);
    done_in = 1'b0; valid = 1'b0;
    check("R5 old value", rdata, ctrl_exp(0, 0, 0));
    bus_rd('h00, d); check("R5 done kept", d, ctrl_exp(0, 1, 0));
    bus_rd('h00, d); check("R5 done then clear", d, ctrl_exp(0, 0, 0));
  endtask

  task automatic t_live_status();
    logic [DW-1:0] d;
    @(negedge clk); idle_in = 1'b0; ready_in = 1'b1;
    bus_rd('h00, d); check("R6 ready only", d, 32'h8);
    @(negedge clk); idle_in = 1'b1; ready_in = 1'b0;
    bus_rd('h00, d); check("R6 idle only", d, 32'h4);
  endtask

  task automatic t_auto();
    logic [DW-1:0] d;
    bus_wr('h00, 32'h80);
    check("R7 auto no start", {31'b0, start}, 0);
    bus_rd('h00, d); check("R7 auto readback", d, ctrl_exp(0, 0, 1));
    pulse_done();
    check("R7 relaunch", {31'b0, start}, 1);
    @(negedge clk); ready_in = 1'b1;
    @(negedge clk); ready_in = 1'b0;
    check("R7 handshake", {31'b0, start}, 0);
    bus_wr('h00, 32'h0);
    bus_rd('h00, d); check("R7 auto off", d, ctrl_exp(0, 1, 0));
    pulse_done();
    check("R7 no relaunch off", {31'b0, start}, 0);
    bus_rd('h00, d);
  endtask

  task automatic t_reserved();
    logic [DW-1:0] d;
    bus_wr('h00, 32'hFFFF_FF7E);
    check("R8 start untouched", {31'b0, start}, 0);
    bus_rd('h00, d); check("R8 reserved zero", d, ctrl_exp(0, 0, 0));
  endtask

  task automatic t_irq_regs();
    logic [DW-1:0] d;
    bus_wr('h04, 32'hFFFF_FFFF);
    bus_wr('h08, 32'hFFFF_FFFF);
    check("R9 no start", {31'b0, start}, 0);
    bus_rd('h04, d); check("R9 gie", d, 32'h1);
    bus_rd('h08, d); check("R9 ier", d, 32'h3);
    bus_rd('h0C, d); check("R9 isr", d, 0);
    bus_rd('h00, d); check("R9 ctrl clean", d, ctrl_exp(0, 0, 0));
  endtask

  task automatic t_params();
    logic [DW-1:0] d;
    for (int k = 0; k < NP; k++) bus_wr(AW'('h10 + 8 * k), 32'hA500_0000 + k * 32'h1111);
    bus_wr('h30, 32'hDEAD_BEEF);
    bus_wr('h14, 32'hDEAD_BEEF);
    for (int k = 0; k < NP; k++) begin
      bus_rd(AW'('h10 + 8 * k), d);
      check("R10 param read", d, 32'hA500_0000 + k * 32'h1111);
      check("R10 param out", params[k*DW +: DW], 32'hA500_0000 + k * 32'h1111);
    end
    bus_rd('h30, d); check("R11 unmapped 0x30", d, 0);
    bus_rd('h14, d); check("R11 unmapped 0x14", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_handshake();
    t_done();
    t_done_collide();
    t_live_status();
    t_auto();
    t_reserved();
    t_irq_regs();
    t_params();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule